// File: doc/BRIEF.md
# CCD Line Region Tagger with Dark-Level Subtraction

This block sits behind the analog-to-digital converter of a full-frame CCD readout. It counts samples along each line and lines within each frame, and attaches a region class to every digitized sample. The classes are dummy, internal test, dark reference, buffer, active and overclock. While a line streams in, it sums the leading dark-reference columns of that line. From that sum it forms a dark level, which it subtracts from the same line's active pixels, clamping the result at zero. Downstream logic keeps only the samples flagged active-valid, and it can watch the dark level as it moves from line to line.

The column classification is built around a state machine that steps through the column regions. Its states are:

- `CS_IDLE`: before the first frame start.
- `CS_DUMMY`, `CS_TEST`, `CS_DARK`, `CS_BUFL`, `CS_ACTIVE`, `CS_BUFR` and `CS_OVER`: the column regions of a line, in readout order.
- `CS_DONE`: the line length has been reached.

The transitions are:

- `CS_IDLE` to `CS_DUMMY` on a frame start.
- From each region state to the next one when the sample at the region's last position is accepted.
- `CS_OVER` to `CS_DONE` on the last sample of the line.
- Any non-idle state back to `CS_DUMMY` on a line or frame start. This is a restart, and it flags an error if the line was short.

A row tracker counts lines from the frame start. It sorts each line into dark, buffer or active. In dark rows and buffer rows, the columns that would otherwise be active or buffer take the row's class instead.

The default geometry is a 4145-sample line and a 4127-line frame:

- Columns: 11 dummy, 4 test, 20 dark, a buffer column, 4096 active columns, a buffer column and 12 overclock samples.
- Rows: 20 dark rows, a buffer row, 4096 active rows, a buffer row and 9 dark rows.

Every region size is a parameter.

Top module: `pxtag_region_clamp`

## Requirements
- R1: From reset until the first `frame_start`, the outputs hold these values: `out_valid`=0, `act_valid`=0, `dark_level`=0 and `line_err`=0. Samples and `line_start` pulses that arrive before the first `frame_start` produce no output.
- R2: Within a line, sample positions are counted from 1. With default sizes, the tags are:
  - positions 1..11: 0 (dummy)
  - positions 12..15: 1 (test)
  - positions 16..35: 2 (dark)
  - positions 36 and 4133: 3 (buffer)
  - positions 37..4132: 4 (active)
  - positions 4134..4145: 5 (overclock)
- R3: Lines are counted from 1 at `frame_start`. Lines 1..20, and every line from 4119 on, are dark rows: their buffer and active columns are tagged 2. Lines 21 and 4118 are buffer rows: those columns are tagged 3. Lines 22..4117 keep the column tag.
- R4: After the last dark-reference sample of a line, `dark_level` shows floor(sum of that line's dark-reference samples / 20) on the following cycle. It keeps that value until the last dark-reference sample of the next line.
- R5: Samples in any column other than the dark-reference columns never change `dark_level`.
- R6: For an active-tagged sample, `out_pix` is the sample minus `dark_level`, clamped at 0. For every other tag, `out_pix` is the raw sample.
- R7: `act_valid` is 1 exactly when an output sample carries tag 4.
- R8: Each accepted sample appears on `out_valid`, `out_tag` and `out_pix` one clock after it is presented. Cycles without `sample_valid` emit nothing.
- R9: A sample presented in the same cycle as `frame_start` or `line_start` is position 1 of the new line. `frame_start` sets the line count to 1, and `line_start` advances it by 1.
- R10: A `line_start` or `frame_start` that arrives before the current line has received its full length of samples sets `line_err`. The flag stays set until reset, and the position count restarts at 1.
- R11: Samples beyond the line length are tagged 5 and never flagged active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start of frame; also starts a line |
| line_start | input | 1 | Start of a new line within the frame |
| sample_valid | input | 1 | Qualifies `sample_data` |
| sample_data | input | DATA_W | Digitized pixel sample |
| out_valid | output | 1 | Output sample present |
| out_tag | output | 3 | Region class of the output sample |
| out_pix | output | DATA_W | Dark-corrected (active) or raw sample |
| act_valid | output | 1 | Output sample is an active pixel |
| dark_level | output | DATA_W | Current line's dark level |
| line_err | output | 1 | Sticky short-line flag |

## Verification
A line restart and a sample can land in the same cycle. That one cycle must close the old line, check for a short line, advance the row and tag the sample as position 1. The bench drives strobes both together with the first sample and alone in an otherwise empty cycle. It compares each tag against a column and row model that it computes arithmetically on its own side. The flagged short line is provoked by a line start that cuts a line off after seven samples. The bench then checks that the flag comes up on that edge, that it stays set, and that the following line still tags correctly from position 1.

// File: rtl/pxtag_pkg.sv
`timescale 1ns/1ps
package pxtag_pkg;

    typedef enum logic [2:0] {
        TAG_DUMMY   = 3'd0,
        TAG_TEST    = 3'd1,
        TAG_DARK    = 3'd2,
        TAG_BUFFER  = 3'd3,
        TAG_ACTIVE  = 3'd4,
        TAG_OVERCLK = 3'd5
    } px_tag_e;

    typedef enum logic [3:0] {
        CS_IDLE,
        CS_DUMMY,
        CS_TEST,
        CS_DARK,
        CS_BUFL,
        CS_ACTIVE,
        CS_BUFR,
        CS_OVER,
        CS_DONE
    } col_state_e;

    typedef enum logic [1:0] {
        RK_DARK,
        RK_BUFFER,
        RK_ACTIVE
    } row_kind_e;

endpackage

// File: rtl/pxtag_col_fsm.sv
`timescale 1ns/1ps
// Column region state machine: position counter, region tag, short-line flag.
module pxtag_col_fsm
    import pxtag_pkg::*;
#(
    parameter int N_DUMMY   = 11,
    parameter int N_TEST    = 4,
    parameter int N_DARK    = 20,
    parameter int N_BUF_COL = 1,
    parameter int N_ACTIVE  = 4096,
    parameter int N_OVER    = 12
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    restart,
    input  logic    sample_valid,
    output px_tag_e col_tag,
    output logic    in_line,
    output logic    dark_take,
    output logic    dark_first,
    output logic    dark_last,
    output logic    line_err
);

    localparam int END_DUMMY = N_DUMMY;
    localparam int END_TEST  = END_DUMMY + N_TEST;
    localparam int END_DARK  = END_TEST + N_DARK;
    localparam int END_BUFL  = END_DARK + N_BUF_COL;
    localparam int END_ACT   = END_BUFL + N_ACTIVE;
    localparam int END_BUFR  = END_ACT + N_BUF_COL;
    localparam int LINE_LEN  = END_BUFR + N_OVER;
    localparam int CNT_W     = $clog2(LINE_LEN + 2);

    localparam logic [CNT_W-1:0] P_DUMMY = CNT_W'(END_DUMMY);
    localparam logic [CNT_W-1:0] P_TEST  = CNT_W'(END_TEST);
    localparam logic [CNT_W-1:0] P_DARK0 = CNT_W'(END_TEST + 1);
    localparam logic [CNT_W-1:0] P_DARK  = CNT_W'(END_DARK);
    localparam logic [CNT_W-1:0] P_BUFL  = CNT_W'(END_BUFL);
    localparam logic [CNT_W-1:0] P_ACT   = CNT_W'(END_ACT);
    localparam logic [CNT_W-1:0] P_BUFR  = CNT_W'(END_BUFR);
    localparam logic [CNT_W-1:0] P_LINE  = CNT_W'(LINE_LEN);

    col_state_e       state_q, state_eff, state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_nxt, pos;
    logic             err_q, err_set, adv;

    // A restart re-enters the dummy region with the counter cleared, so a
    // sample in the same cycle takes position 1.
    always_comb begin
        state_eff = restart ? CS_DUMMY : state_q;
        cnt_eff   = restart ? '0 : cnt_q;
        pos       = cnt_eff + 1'b1;
        adv       = sample_valid;
        err_set   = restart && (state_q != CS_IDLE) && (cnt_q < P_LINE);
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_eff;
        unique case (state_eff)
            CS_IDLE:   state_nxt = CS_IDLE;
            CS_DUMMY:  if (adv && pos == P_DUMMY) state_nxt = CS_TEST;
            CS_TEST:   if (adv && pos == P_TEST)  state_nxt = CS_DARK;
            CS_DARK:   if (adv && pos == P_DARK)  state_nxt = CS_BUFL;
            CS_BUFL:   if (adv && pos == P_BUFL)  state_nxt = CS_ACTIVE;
            CS_ACTIVE: if (adv && pos == P_ACT)   state_nxt = CS_BUFR;
            CS_BUFR:   if (adv && pos == P_BUFR)  state_nxt = CS_OVER;
            CS_OVER:   if (adv && pos == P_LINE)  state_nxt = CS_DONE;
            CS_DONE:   state_nxt = CS_DONE;
            default:   state_nxt = CS_IDLE;
        endcase
        cnt_nxt = (adv && state_eff != CS_IDLE && state_eff != CS_DONE) ? pos : cnt_eff;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            if (err_set) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_eff)
            CS_DUMMY:  col_tag = TAG_DUMMY;
            CS_TEST:   col_tag = TAG_TEST;
            CS_DARK:   col_tag = TAG_DARK;
            CS_BUFL:   col_tag = TAG_BUFFER;
            CS_ACTIVE: col_tag = TAG_ACTIVE;
            CS_BUFR:   col_tag = TAG_BUFFER;
            CS_OVER:   col_tag = TAG_OVERCLK;
            CS_DONE:   col_tag = TAG_OVERCLK;
            default:   col_tag = TAG_DUMMY;
        endcase
        in_line    = sample_valid && (state_eff != CS_IDLE);
        dark_take  = in_line && (state_eff == CS_DARK);
        dark_first = dark_take && (pos == P_DARK0);
        dark_last  = dark_take && (pos == P_DARK);
        line_err   = err_q;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= P_LINE);                                             // R11
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_DONE) |-> (cnt_q == P_LINE));                  // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);                                             // R10
    AST_RESTART_POS1: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && sample_valid) |=> (cnt_q == CNT_W'(1)));          // R9

endmodule

// File: rtl/pxtag_row_track.sv
`timescale 1ns/1ps
// Line counter within a frame and row classification.
module pxtag_row_track
    import pxtag_pkg::*;
#(
    parameter int N_DARK_TOP = 20,
    parameter int N_BUF_ROW  = 1,
    parameter int N_ACT_ROWS = 4096,
    parameter int N_DARK_BOT = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      line_start,
    output logic      framed,
    output row_kind_e row_kind
);

    localparam int END_TOP  = N_DARK_TOP;
    localparam int END_BUFT = END_TOP + N_BUF_ROW;
    localparam int END_ACT  = END_BUFT + N_ACT_ROWS;
    localparam int END_BUFB = END_ACT + N_BUF_ROW;
    localparam int ROW_SAT  = END_BUFB + N_DARK_BOT + 1;
    localparam int ROW_W    = $clog2(ROW_SAT + 1);

    localparam logic [ROW_W-1:0] P_TOP  = ROW_W'(END_TOP);
    localparam logic [ROW_W-1:0] P_BUFT = ROW_W'(END_BUFT);
    localparam logic [ROW_W-1:0] P_ACT  = ROW_W'(END_ACT);
    localparam logic [ROW_W-1:0] P_BUFB = ROW_W'(END_BUFB);
    localparam logic [ROW_W-1:0] P_SAT  = ROW_W'(ROW_SAT);

    logic [ROW_W-1:0] row_q, row_eff;

    always_comb begin
        if (frame_start)
            row_eff = ROW_W'(1);
        else if (line_start && row_q != '0 && row_q != P_SAT)
            row_eff = row_q + 1'b1;
        else
            row_eff = row_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_eff;
    end

    always_comb begin
        framed = (row_q != '0);
        if (row_eff <= P_TOP)       row_kind = RK_DARK;
        else if (row_eff <= P_BUFT) row_kind = RK_BUFFER;
        else if (row_eff <= P_ACT)  row_kind = RK_ACTIVE;
        else if (row_eff <= P_BUFB) row_kind = RK_BUFFER;
        else                        row_kind = RK_DARK;
    end

    AST_ROW_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= P_SAT);                                              // R3
    AST_FRAME_ROW1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (row_q == ROW_W'(1)));                        // R9

endmodule

// File: rtl/pxtag_dark_est.sv
`timescale 1ns/1ps
// Per-line dark sum and division by a reciprocal constant.
module pxtag_dark_est #(
    parameter int DATA_W = 14,
    parameter int N_DARK = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_data,
    input  logic              dark_take,
    input  logic              dark_first,
    input  logic              dark_last,
    output logic [DATA_W-1:0] dark_level
);

    localparam int SUM_W  = DATA_W + $clog2(N_DARK + 1);
    localparam int SHIFT  = SUM_W + $clog2(N_DARK) + 1;
    localparam int PROD_W = SUM_W + SHIFT + 1;
    localparam longint unsigned RECIP_L = ((64'd1 << SHIFT) + 64'(N_DARK) - 64'd1) / 64'(N_DARK);
    localparam logic [SHIFT:0] RECIP = (SHIFT + 1)'(RECIP_L);

    logic [SUM_W-1:0]  acc_q, sum_now;
    logic [PROD_W-1:0] prod;
    logic [DATA_W-1:0] dark_q, dark_nxt;

    always_comb begin
        sum_now  = dark_first ? SUM_W'(sample_data) : acc_q + SUM_W'(sample_data);
        prod     = {{(SHIFT + 1){1'b0}}, sum_now} * {{SUM_W{1'b0}}, RECIP};
        dark_nxt = DATA_W'(prod >> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            dark_q <= '0;
        end else begin
            if (dark_take) acc_q  <= sum_now;
            if (dark_last) dark_q <= dark_nxt;
        end
    end

    assign dark_level = dark_q;

    AST_DARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dark_last |=> $stable(dark_q));                              // R5
    AST_DARK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dark_last |=> (SUM_W'(dark_q) * SUM_W'(N_DARK) <= $past(sum_now))); // R4

endmodule

// File: rtl/pxtag_region_clamp.sv
`timescale 1ns/1ps
// Top: region tagging, dark subtraction and the registered output stage.
module pxtag_region_clamp
    import pxtag_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int N_DUMMY    = 11,
    parameter int N_TEST     = 4,
    parameter int N_DARK     = 20,
    parameter int N_BUF_COL  = 1,
    parameter int N_ACTIVE   = 4096,
    parameter int N_OVER     = 12,
    parameter int N_DARK_TOP = 20,
    parameter int N_BUF_ROW  = 1,
    parameter int N_ACT_ROWS = 4096,
    parameter int N_DARK_BOT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    output logic              out_valid,
    output logic [2:0]        out_tag,
    output logic [DATA_W-1:0] out_pix,
    output logic              act_valid,
    output logic [DATA_W-1:0] dark_level,
    output logic              line_err
);

    px_tag_e           col_tag, tag_now, tag_q;
    row_kind_e         row_kind;
    logic              framed, restart, in_line;
    logic              dark_take, dark_first, dark_last;
    logic [DATA_W-1:0] corr, dark_cur;
    logic              valid_q, act_q;
    logic [DATA_W-1:0] pix_q;

    assign restart = frame_start || (line_start && framed);

    pxtag_row_track #(
        .N_DARK_TOP (N_DARK_TOP),
        .N_BUF_ROW  (N_BUF_ROW),
        .N_ACT_ROWS (N_ACT_ROWS),
        .N_DARK_BOT (N_DARK_BOT)
    ) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .framed      (framed),
        .row_kind    (row_kind)
    );

    pxtag_col_fsm #(
        .N_DUMMY   (N_DUMMY),
        .N_TEST    (N_TEST),
        .N_DARK    (N_DARK),
        .N_BUF_COL (N_BUF_COL),
        .N_ACTIVE  (N_ACTIVE),
        .N_OVER    (N_OVER)
    ) u_cols (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .sample_valid (sample_valid),
        .col_tag      (col_tag),
        .in_line      (in_line),
        .dark_take    (dark_take),
        .dark_first   (dark_first),
        .dark_last    (dark_last),
        .line_err     (line_err)
    );

    pxtag_dark_est #(
        .DATA_W (DATA_W),
        .N_DARK (N_DARK)
    ) u_dark (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_data (sample_data),
        .dark_take   (dark_take),
        .dark_first  (dark_first),
        .dark_last   (dark_last),
        .dark_level  (dark_cur)
    );

    // Rows outside the active band override the buffer and active columns.
    always_comb begin
        tag_now = col_tag;
        if (col_tag == TAG_BUFFER || col_tag == TAG_ACTIVE) begin
            unique case (row_kind)
                RK_DARK:   tag_now = TAG_DARK;
                RK_BUFFER: tag_now = TAG_BUFFER;
                RK_ACTIVE: tag_now = col_tag;
                default:   tag_now = col_tag;
            endcase
        end
        corr = (sample_data > dark_cur) ? (sample_data - dark_cur) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            act_q   <= 1'b0;
            tag_q   <= TAG_DUMMY;
            pix_q   <= '0;
        end else begin
            valid_q <= in_line;
            act_q   <= in_line && (tag_now == TAG_ACTIVE);
            if (in_line) begin
                tag_q <= tag_now;
                pix_q <= (tag_now == TAG_ACTIVE) ? corr : sample_data;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_tag    = tag_q;
    assign out_pix    = pix_q;
    assign act_valid  = act_q;
    assign dark_level = dark_cur;

    AST_ACT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (out_valid && out_tag == 3'(TAG_ACTIVE)));      // R7
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_valid));                           // R8
    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (out_pix <= $past(sample_data)));               // R6
    AST_PRE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed && !frame_start) |=> !out_valid);                    // R1
    AST_OVER_NOT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag == 3'(TAG_OVERCLK)) |-> !act_valid);                 // R11

endmodule

// File: tb/pxtag_region_clamp_bench.sv
`timescale 1ns/1ps
module pxtag_region_clamp_bench;

    localparam int DW   = 8;
    localparam int ND   = 2;
    localparam int NT   = 1;
    localparam int NK   = 3;
    localparam int NB   = 1;
    localparam int NA   = 5;
    localparam int NO   = 2;
    localparam int LEN  = ND + NT + NK + NB + NA + NB + NO;
    localparam int RT   = 2;
    localparam int RB   = 1;
    localparam int RA   = 3;
    localparam int RBOT = 1;
    localparam int RSAT = RT + RB + RA + RB + RBOT + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, line_start = 1'b0, sample_valid = 1'b0;
    logic [DW-1:0] sample_data = '0;
    logic out_valid, act_valid, line_err;
    logic [2:0] out_tag;
    logic [DW-1:0] out_pix, dark_level;

    always #2.5 clk = ~clk;

    pxtag_region_clamp #(
        .DATA_W (DW), .N_DUMMY (ND), .N_TEST (NT), .N_DARK (NK),
        .N_BUF_COL (NB), .N_ACTIVE (NA), .N_OVER (NO),
        .N_DARK_TOP (RT), .N_BUF_ROW (RB), .N_ACT_ROWS (RA), .N_DARK_BOT (RBOT)
    ) u_pxtag_region_clamp (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .line_start (line_start), .sample_valid (sample_valid),
        .sample_data (sample_data), .out_valid (out_valid), .out_tag (out_tag),
        .out_pix (out_pix), .act_valid (act_valid), .dark_level (dark_level),
        .line_err (line_err)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int m_row = 0, m_pos = 0, m_sum = 0, m_dark = 0;
    bit m_err = 1'b0;
    int unsigned lcg = 32'h0000_1234;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int col_class(input int p);
        if (p <= ND)                     return 0;
        if (p <= ND + NT)                return 1;
        if (p <= ND + NT + NK)           return 2;
        if (p == ND + NT + NK + NB)      return 3;
        if (p <= ND + NT + NK + NB + NA) return 4;
        if (p == LEN - NO)               return 3;
        return 5;
    endfunction

    function automatic int full_tag(input int p, input int row);
        int c = col_class(p);
        if (c != 3 && c != 4) return c;
        if (row <= RT || row > RT + RB + RA + RB) return 2;
        if (row == RT + RB || row == RT + RB + RA + RB) return 3;
        return c;
    endfunction

    function automatic int next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) & 32'hFF);
    endfunction

    task automatic cyc(input bit v, input int d, input bit fs, input bit ls);
        int p, et, ep;
        bit ev;
        string rq;
        sample_valid = v; sample_data = DW'(d); frame_start = fs; line_start = ls;
        if (fs) begin
            if (m_row != 0 && m_pos < LEN) m_err = 1'b1;
            m_row = 1; m_pos = 0;
        end else if (ls && m_row != 0) begin
            if (m_pos < LEN) m_err = 1'b1;
            if (m_row < RSAT) m_row++;
            m_pos = 0;
        end
        ev = v && (m_row != 0);
        et = 0; ep = 0;
        if (ev) begin
            m_pos++;
            p  = m_pos;
            et = full_tag(p, m_row);
            ep = (et == 4) ? ((d > m_dark) ? d - m_dark : 0) : d;
            if (p > ND + NT && p <= ND + NT + NK) begin
                m_sum = (p == ND + NT + 1) ? d : m_sum + d;
                if (p == ND + NT + NK) m_dark = m_sum / NK;
            end
        end
        @(negedge clk);
        chk(out_valid == ev, "R8 R1", "out_valid", out_valid, ev);
        if (ev) begin
            rq = (m_pos > LEN) ? "R11" : "R2 R3 R9";
            chk(out_tag == 3'(et), rq, "out_tag", out_tag, et);
            chk(out_pix == DW'(ep), "R6", "out_pix", out_pix, ep);
            chk(act_valid == (et == 4), "R7", "act_valid", act_valid, et == 4);
        end
        chk(dark_level == DW'(m_dark), "R4 R5", "dark_level", dark_level, m_dark);
        chk(line_err == m_err, "R10", "line_err", line_err, m_err);
        sample_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
    endtask

    // One line: strobe with or ahead of the first sample, optional gaps,
    // optional high dark-reference values.
    task automatic run_line(input bit fs, input bit ls, input bit together,
                            input int n, input bit gaps, input int bias);
        if (!together) cyc(1'b0, 0, fs, ls);
        for (int i = 1; i <= n; i++) begin
            int d = next_rand();
            if (i > ND + NT && i <= ND + NT + NK)
                d = (bias > 0) ? bias + i * 5 : (d & 8'h3F);
            if (together && i == 1) cyc(1'b1, d, fs, ls);
            else                    cyc(1'b1, d, 1'b0, 1'b0);
            if (gaps && (i % 3 == 0)) cyc(1'b0, 0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        chk(act_valid == 0, "R1", "act_valid in reset", act_valid, 0);
        chk(dark_level == 0, "R1", "dark_level in reset", dark_level, 0);
        chk(line_err == 0, "R1", "line_err in reset", line_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: traffic before the first frame start is ignored
        cyc(1'b1, 55, 1'b0, 1'b0);
        cyc(1'b1, 9, 1'b0, 1'b1);
        cyc(1'b1, 200, 1'b0, 1'b0);
        // Frame A: strobes with the first sample; past the last row (R3)
        for (int l = 0; l < 10; l++)
            run_line(l == 0, l != 0, 1'b1, LEN, l % 2 == 1, (l == 4) ? 200 : 0);
        // Frame B: strobes alone; an overlong line (R11); a high dark line (R6)
        for (int l = 0; l < 8; l++)
            run_line(l == 0, l != 0, 1'b0, (l == 2) ? LEN + 3 : LEN, l % 2 == 0,
                     (l == 4) ? 220 : 0);
        // R10: short line, then a full line from position 1, then a new frame
        run_line(1'b0, 1'b1, 1'b1, 7, 1'b0, 0);
        run_line(1'b0, 1'b1, 1'b1, LEN, 1'b0, 0);
        run_line(1'b1, 1'b0, 1'b0, LEN, 1'b1, 0);
        done = 1'b1;
        finish_up();
    end

endmodule